// File: doc/BRIEF.md
# Custom Opcode Stall Sequencer

This block sits next to an 8-bit processor core and executes three opcodes that the core's own decoder does not handle. When the core decodes one of them, it presents the opcode and the following operand byte for one cycle with `op_valid`. The sequencer then holds `stall` high until the operation is complete. The three operations are a permanent stop, a wait for a counted number of frame-sync edges from the display side, and a clear of the 1 KB character screen.

The screen storage cannot be read by the core, so a shadow copy in main RAM mirrors it. The clear therefore writes the blank character through two write ports in lockstep. One port addresses the screen window and the other addresses the shadow window. The frame-sync input comes from another clock domain. It passes through a synchroniser before its rising edges are counted. The display logic is separate and keeps running while the core is stopped.

Top module: `cop_stall_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `stall`, `halted`, `txt_we`, `shd_we` and `clr_done` are all low.
- R2: An opcode is accepted only when `stall` is low and `op_valid` is high on a rising clock edge. `stall` rises in the cycle after acceptance. Any opcode value other than 0xEF, 0xFF or 0xCF is ignored, and `stall` stays low.
- R3: Opcode 0xEF drives `stall` and `halted` high from the next cycle onward. Only `rst_n` low clears them. Frame syncs and further opcodes have no effect on them.
- R4: Opcode 0xFF with operand N keeps `stall` high until N+1 frame-sync rising edges have been counted. `stall` falls in the cycle after the edge that completes the count. Operand 0x00 therefore waits for exactly one edge.
- R5: Frame syncs are counted as 0-to-1 transitions of `vsync_async` after a two-flop synchroniser. A sync seen on a clock edge reaches the counter on the second edge after that. A level that is already high when a wait starts is not counted, and a high pulse of any length counts once.
- R6: Opcode 0xCF performs 1024 consecutive write cycles, one per clock, with `txt_we` and `shd_we` both high. In write cycle i, counting from 0 in ascending order, `txt_addr` is 0xE000+i, `shd_addr` is 0x7C00+i and `fill_data` is 0x20.
- R7: `clr_done` is high for exactly one cycle, the cycle right after the last clear write. `stall` is still high in that cycle and is low in the next one.
- R8: `op_valid` has no effect while `stall` is high. It does not extend, restart or change the operation in progress.
- R9: After a wait or a clear, a new opcode presented in the first cycle with `stall` low is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe that presents an opcode from the core |
| op_code | input | 8 | Opcode byte |
| op_arg | input | 8 | Operand byte (used by the wait opcode) |
| vsync_async | input | 1 | Frame sync from the display clock domain |
| stall | output | 1 | Holds the core while an operation is running |
| halted | output | 1 | High in the permanent stop state |
| txt_we | output | 1 | Write enable into the screen memory |
| txt_addr | output | 16 | Screen write address |
| shd_we | output | 1 | Write enable into the shadow copy |
| shd_addr | output | 16 | Shadow write address |
| fill_data | output | 8 | Write data (the blank code) |
| clr_done | output | 1 | One-cycle pulse when a clear completes |

## Verification
The assertions assume that the core raises `op_valid` only for one cycle at a time and never while `stall` is high. They also assume that reset is the only way out of a stop. The bench follows this for all normal traffic. It still injects opcodes during a wait, during a clear and during a stop, to show that the block ignores them. The frame-sync input is driven away from the clock edge and its pulses are held for several cycles, so every transition passes cleanly through the synchroniser. One wait starts while the sync level is already high, to exercise the rule that the frame in progress is not counted.

// File: rtl/cop_pkg.sv
package cop_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_HALT  = 3'd1,
      SQ_WAIT  = 3'd2,
      SQ_CLEAR = 3'd3,
      SQ_DONE  = 3'd4
   } seq_state_t;

endpackage

// File: rtl/cop_vsync_edge.sv
module cop_vsync_edge #(
   parameter int STAGES = 2,
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic edge_o
);
   localparam int CHAIN_W = STAGES + 1;

   logic [CHAIN_W-1:0] chain_q;

   initial begin
      if (STAGES < 2) $fatal(1, "cop_vsync_edge: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN_W-2:0], async_in};
   end

   generate
      if (RISING) begin : g_rise
         assign edge_o = chain_q[STAGES-1] & ~chain_q[STAGES];
      end else begin : g_fall
         assign edge_o = ~chain_q[STAGES-1] & chain_q[STAGES];
      end
   endgenerate

endmodule

// File: rtl/cop_frame_wait.sv
module cop_frame_wait #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             last_o
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      remain_q <= '0;
      else if (load)                   remain_q <= load_val;
      else if (tick && remain_q != '0) remain_q <= remain_q - 1'b1;
   end

   assign last_o = tick && (remain_q == '0);

endmodule

// File: rtl/cop_fill_walker.sv
module cop_fill_walker #(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   output logic [IDX_W-1:0] idx_o,
   output logic             last_o
);
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (start) idx_q <= '0;
      else if (run)   idx_q <= idx_q + 1'b1;
   end

   assign idx_o  = idx_q;
   assign last_o = run && (idx_q == {IDX_W{1'b1}});

endmodule

// File: rtl/cop_stall_seq.sv
module cop_stall_seq #(
   parameter int          DATA_W      = 8,
   parameter int          ADDR_W      = 16,
   parameter int          IDX_W       = 10,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] TXT_BASE    = 16'hE000,
   parameter logic [15:0] SHD_BASE    = 16'h7C00,
   parameter logic [7:0]  FILL_CODE   = 8'h20,
   parameter logic [7:0]  OPC_HALT    = 8'hEF,
   parameter logic [7:0]  OPC_WAIT    = 8'hFF,
   parameter logic [7:0]  OPC_CLEAR   = 8'hCF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [7:0]        op_code,
   input  logic [7:0]        op_arg,
   input  logic              vsync_async,
   output logic              stall,
   output logic              halted,
   output logic              txt_we,
   output logic [ADDR_W-1:0] txt_addr,
   output logic              shd_we,
   output logic [ADDR_W-1:0] shd_addr,
   output logic [DATA_W-1:0] fill_data,
   output logic              clr_done
);
   import cop_pkg::*;

   localparam int DEPTH = 1 << IDX_W;

   initial begin
      if (IDX_W >= ADDR_W) $fatal(1, "cop_stall_seq: IDX_W must be below ADDR_W");
      if ((int'(TXT_BASE) % DEPTH) != 0) $fatal(1, "cop_stall_seq: TXT_BASE not aligned");
      if ((int'(SHD_BASE) % DEPTH) != 0) $fatal(1, "cop_stall_seq: SHD_BASE not aligned");
      if (DATA_W < 8) $fatal(1, "cop_stall_seq: DATA_W too small");
   end

   seq_state_t       state_q, state_d;
   logic             sync_edge;
   logic             wait_last;
   logic             fill_last;
   logic [IDX_W-1:0] fill_idx;
   logic             accept;
   logic             go_wait, go_clear;

   assign accept   = op_valid && (state_q == SQ_IDLE);
   assign go_wait  = accept && (op_code == OPC_WAIT);
   assign go_clear = accept && (op_code == OPC_CLEAR);

   cop_vsync_edge #(.STAGES(SYNC_STAGES), .RISING(1'b1)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (vsync_async),
      .edge_o   (sync_edge)
   );

   cop_frame_wait #(.CNT_W(8)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go_wait),
      .load_val (op_arg),
      .tick     (sync_edge && (state_q == SQ_WAIT)),
      .last_o   (wait_last)
   );

   cop_fill_walker #(.IDX_W(IDX_W)) u_fill (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (go_clear),
      .run    (state_q == SQ_CLEAR),
      .idx_o  (fill_idx),
      .last_o (fill_last)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (accept) begin
               if (op_code == OPC_HALT)       state_d = SQ_HALT;
               else if (op_code == OPC_WAIT)  state_d = SQ_WAIT;
               else if (op_code == OPC_CLEAR) state_d = SQ_CLEAR;
            end
         end
         SQ_HALT:  state_d = SQ_HALT;
         SQ_WAIT:  if (wait_last) state_d = SQ_IDLE;
         SQ_CLEAR: if (fill_last) state_d = SQ_DONE;
         SQ_DONE:  state_d = SQ_IDLE;
         default:  state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_IDLE;
      else        state_q <= state_d;
   end

   assign stall     = (state_q != SQ_IDLE);
   assign halted    = (state_q == SQ_HALT);
   assign txt_we    = (state_q == SQ_CLEAR);
   assign shd_we    = (state_q == SQ_CLEAR);
   assign txt_addr  = TXT_BASE + ADDR_W'(fill_idx);
   assign shd_addr  = SHD_BASE + ADDR_W'(fill_idx);
   assign fill_data = DATA_W'(FILL_CODE);
   assign clr_done  = (state_q == SQ_DONE);

endmodule

// File: rtl/cop_stall_seq_chk.sv
module cop_stall_seq_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic              stall,
   input logic              halted,
   input logic              txt_we,
   input logic [ADDR_W-1:0] txt_addr,
   input logic              shd_we,
   input logic [ADDR_W-1:0] shd_addr,
   input logic              clr_done
);
   // R2: the stall only starts after an accepted strobe
   a_r2_stall_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall) |-> $past(op_valid));

   // R3: a stop never ends without reset
   a_r3_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> (halted && stall));

   // R6: the two write ports move together
   a_r6_ports_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
      txt_we |-> (shd_we && stall));

   // R6: consecutive writes step the address by one
   a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (txt_we && $past(txt_we)) |-> (txt_addr == $past(txt_addr) + 1'b1)
                                   && (shd_addr == $past(shd_addr) + 1'b1));

   // R7: the done pulse follows the last write
   a_r7_done_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(txt_we) |-> clr_done);

   // R7: the stall drops right after the done pulse
   a_r7_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      clr_done |=> (!stall && !clr_done));

   // R8: only one activity at a time
   a_r8_one_activity: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({txt_we, clr_done, halted}));

endmodule

bind cop_stall_seq cop_stall_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .stall    (stall),
   .halted   (halted),
   .txt_we   (txt_we),
   .txt_addr (txt_addr),
   .shd_we   (shd_we),
   .shd_addr (shd_addr),
   .clr_done (clr_done)
);

// File: tb/cop_stall_seq_tb.sv
`timescale 1ns/1ps
module cop_stall_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [7:0]  op_code = 8'h00;
   logic [7:0]  op_arg = 8'h00;
   logic        vsync_async = 1'b0;
   logic        stall, halted, txt_we, shd_we, clr_done;
   logic [15:0] txt_addr, shd_addr;
   logic [7:0]  fill_data;

   always #2 clk = ~clk;

   cop_stall_seq dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_arg(op_arg), .vsync_async(vsync_async), .stall(stall),
      .halted(halted), .txt_we(txt_we), .txt_addr(txt_addr),
      .shd_we(shd_we), .shd_addr(shd_addr), .fill_data(fill_data),
      .clr_done(clr_done)
   );

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done_flag = 0;

   // behavioural reference: 0 idle, 1 stop, 2 wait, 3 clear, 4 done
   int       m_mode = 0;
   int       m_cnt = 0;
   int       m_idx = 0;
   bit [2:0] m_hist = '0;
   int       writes = 0;
   logic [7:0] txt_mem [1024];
   logic [7:0] shd_mem [1024];

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit edge_seen;
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_idx = 0; m_hist = '0;
      end else begin
         // R5: edge is visible two clocks after sampling
         edge_seen = m_hist[1] && !m_hist[2];
         case (m_mode)
            0: if (op_valid) begin
                  if (op_code == 8'hEF) m_mode = 1;
                  else if (op_code == 8'hFF) begin m_mode = 2; m_cnt = op_arg; end
                  else if (op_code == 8'hCF) begin m_mode = 3; m_idx = 0; end
               end
            2: if (edge_seen) begin
                  if (m_cnt == 0) m_mode = 0; else m_cnt--;
               end
            3: if (m_idx == 1023) m_mode = 4; else m_idx++;
            4: m_mode = 0;
            default: ;
         endcase
         m_hist = {m_hist[1:0], vsync_async};
      end
   end

   always @(negedge clk) begin
      string tag;
      if (rst_n && !done_flag) begin
         case (m_mode)
            0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R6"; default: tag = "R7";
         endcase
         chk(tag, "stall", int'(stall), int'(m_mode != 0));
         chk(tag, "halted", int'(halted), int'(m_mode == 1));
         chk(tag, "txt_we", int'(txt_we), int'(m_mode == 3));
         chk(tag, "shd_we", int'(shd_we), int'(m_mode == 3));
         chk(tag, "clr_done", int'(clr_done), int'(m_mode == 4));
         if (m_mode == 3) begin
            chk("R6", "txt_addr", int'(txt_addr), 32'hE000 + m_idx);
            chk("R6", "shd_addr", int'(shd_addr), 32'h7C00 + m_idx);
            chk("R6", "fill_data", int'(fill_data), 32'h20);
         end
         if (txt_we) begin
            writes++;
            if (txt_addr >= 16'hE000 && txt_addr < 16'hE400) txt_mem[txt_addr - 16'hE000] = fill_data;
            if (shd_addr >= 16'h7C00 && shd_addr < 16'h8000) shd_mem[shd_addr - 16'h7C00] = fill_data;
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done_flag) begin
         done_flag = 1;
         failures++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic issue(logic [7:0] c, logic [7:0] a);
      op_code = c; op_arg = a; op_valid = 1'b1;
      step(1);
      op_valid = 1'b0;
   endtask

   task automatic vpulse(int hi, int lo);
      vsync_async = 1'b1; step(hi);
      vsync_async = 1'b0; step(lo);
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) begin txt_mem[i] = 8'hFF; shd_mem[i] = 8'hFF; end
      @(negedge clk);
      step(3);
      // R1: outputs during reset
      chk("R1", "stall in reset", int'(stall), 0);
      chk("R1", "we in reset", int'(txt_we | shd_we), 0);
      rst_n = 1'b1;
      step(1);
      chk("R1", "halted after reset", int'(halted), 0);
      chk("R1", "done after reset", int'(clr_done), 0);

      // R2: unknown opcode ignored
      issue(8'hEA, 8'h00);
      step(2);
      chk("R2", "stall after unknown opcode", int'(stall), 0);

      // R4: operand zero waits one edge
      issue(8'hFF, 8'h00);
      step(5);
      chk("R4", "stall waiting", int'(stall), 1);
      vpulse(4, 8);
      chk("R4", "released after one sync", int'(stall), 0);

      // R5: wait starting while the sync level is high
      vsync_async = 1'b1; step(6);
      issue(8'hFF, 8'h02);
      step(10);
      vsync_async = 1'b0; step(5);
      chk("R5", "high level not counted", int'(stall), 1);
      vpulse(20, 6);
      // R8: opcode during a wait is ignored
      issue(8'hCF, 8'h00);
      step(3);
      chk("R8", "no writes during wait", int'(txt_we), 0);
      vpulse(3, 6);
      chk("R5", "two of three edges", int'(stall), 1);
      vpulse(3, 6);
      chk("R4", "released after three syncs", int'(stall), 0);

      // R6: full clear with syncs and an ignored opcode during it
      writes = 0;
      issue(8'hCF, 8'h00);
      vpulse(3, 3);
      issue(8'hEF, 8'h00);
      step(1100);
      chk("R6", "write count", writes, 1024);
      begin
         int bad = 0;
         for (int i = 0; i < 1024; i++)
            if (txt_mem[i] !== 8'h20 || shd_mem[i] !== 8'h20) bad++;
         chk("R6", "locations not blank", bad, 0);
      end
      chk("R8", "stop ignored during clear", int'(halted), 0);

      // R9: back-to-back operation after a wait
      issue(8'hFF, 8'h00);
      vpulse(3, 0);
      while (stall) step(1);
      issue(8'hFF, 8'h01);
      step(2);
      chk("R9", "wait accepted right away", int'(stall), 1);
      vpulse(3, 5);
      vpulse(3, 5);
      chk("R9", "second wait finished", int'(stall), 0);

      // R3: stop is permanent
      issue(8'hEF, 8'h00);
      vpulse(3, 5);
      issue(8'hCF, 8'h00);
      issue(8'hFF, 8'h00);
      step(20);
      chk("R3", "still halted", int'(halted), 1);
      chk("R3", "still stalled", int'(stall), 1);
      rst_n = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
      chk("R3", "reset leaves stop", int'(halted | stall), 0);
      chk("R1", "idle after reset", int'(txt_we | clr_done), 0);
      step(5);

      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule